// File: doc/BRIEF.md
# Programmable CPU address window decoder

This block holds a bank of software-programmed decode windows and uses them to steer every CPU physical address to a device. A device is named by a 4-bit target and an 8-bit attribute. Each window has a power-of-two size, counted in 64 KiB granules, and a base that is aligned to that size. A small group of low-numbered windows can also translate the address through a per-window remap value. All windows are compared against the lookup address in parallel. The lowest-numbered window that hits supplies the result, and a separate flag reports when more than one window hit.

Software reaches the windows through a plain 32-bit register port: an 8-bit byte offset, a write enable, write data, and read data that follows the offset combinationally. The register map is irregular. Windows with remap have four words each. The hole comes next, then the windows without remap at two words each, and then a read-only status word that marks windows with an illegal size or base. A lookup is a one-cycle request. The result is registered and is held until the next request.

Top module: `cpu_win_decoder`

## Requirements
- R1: After reset every register, including the status word at 0xF0, reads zero, and no lookup hits.
- R2: The control word holds the enable in bit 0, the target in bits 7:4, the attribute in bits 15:8 and the size in 64 KiB granules minus one in bits 31:16. Bits 3:1 read as zero.
- R3: The base word holds address bits 31:16 in bits 31:16 and address bits 35:32 in bits 3:0, and its other bits read zero. The remap-high word keeps only bits 3:0 (address bits 35:32), and the remap-low word keeps only bits 31:16.
- R4: A window whose enable is clear never hits, and writing zero to its control and base words removes it from decoding.
- R5: With size field s, an enabled window hits when address bits 35:32 equal its base bits 35:32 and (addr[31:16] & ~s) equals (base[31:16] & ~s). Address bits 15:0 are always inside the window.
- R6: When several windows hit, the lowest index wins, and the overlap output is 1 exactly when two or more windows hit.
- R7: For windows 0 to 7, the translated address is {remap-high bits 3:0, (remap-low[31:16] & ~s) | (addr[31:16] & s), addr[15:0]}.
- R8: For windows 8 to 19, and on a miss, the translated address equals the lookup address.
- R9: Window w below 8 has its control, base, remap-low and remap-high words at 16*w + 0, 4, 8 and C. Window w from 8 to 19 has its control and base words at 0x90 + 8*(w-8) + 0 and 4.
- R10: The hole at 0x80 to 0x8F and the offsets above 0xF0 read zero, and writes to them change no register.
- R11: Bit w of the read-only status word at 0xF0 is 1 when window w is enabled and either s+1 is not a power of two or base[31:16] & s is nonzero.
- R12: A request in one cycle gives lk_rsp_valid in the next cycle only. On a miss, hit, target, attribute, index and overlap are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 36 | Physical address to decode |
| lk_rsp_valid | output | 1 | Lookup result valid, one cycle after the request |
| lk_hit | output | 1 | Some enabled window matched |
| lk_target | output | 4 | Target of the winning window |
| lk_attr | output | 8 | Attribute of the winning window |
| lk_win | output | 5 | Index of the winning window |
| lk_overlap | output | 1 | Two or more windows matched |
| lk_addr_out | output | 36 | Translated address |

## Verification
The hardest cases to reach from the ports are an address that falls inside two enabled windows where the winner also remaps, and a window whose misaligned base still decodes under its masked compare. The stimulus programs a large window without remap on top of a small remapping window at a lower index, so one lookup exercises priority, the overlap flag and remap together. Deleting the low window then shows the high window winning alone. Two more windows are given an illegal size and a misaligned base, and both the status word and their masked hits are checked.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

    localparam int DEF_NUM_WIN   = 20;
    localparam int DEF_NUM_REMAP = 8;
    localparam int DEF_HOLE      = 16;
    localparam int PA_W          = 36;

    typedef struct packed {
        logic [15:0] size_m1;
        logic [7:0]  attr;
        logic [3:0]  target;
        logic        en;
    } win_ctrl_t;

    typedef struct packed {
        logic [3:0]  hi;
        logic [15:0] lo;
    } win_addr_t;

    // Byte offset of the first word of window w; w == nw gives the status offset.
    function automatic int win_offset(int w, int nr, int hole);
        if (w < nr) return w * 16;
        return nr * 16 + hole + (w - nr) * 8;
    endfunction

endpackage

// File: rtl/cwd_regfile.sv
module cwd_regfile
    import cwd_pkg::*;
#(
    parameter int NW   = DEF_NUM_WIN,
    parameter int NR   = DEF_NUM_REMAP,
    parameter int HOLE = DEF_HOLE,
    parameter int AW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   reg_addr,
    input  logic            reg_wen,
    input  logic [31:0]     reg_wdata,
    input  logic [NW-1:0]   inval_vec,
    output logic [31:0]     reg_rdata,
    output win_ctrl_t       ctrl_q  [NW],
    output win_addr_t       base_q  [NW],
    output win_addr_t       remap_q [NR]
);
    localparam int STATUS_WORD = win_offset(NW, NR, HOLE) / 4;

    logic [31:0] widx;
    assign widx = 32'(reg_addr[AW-1:2]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NW; w++) begin
                ctrl_q[w] <= '0;
                base_q[w] <= '0;
            end
            for (int w = 0; w < NR; w++) remap_q[w] <= '0;
        end else if (reg_wen) begin
            for (int w = 0; w < NW; w++) begin
                if (widx == 32'(win_offset(w, NR, HOLE) / 4))
                    ctrl_q[w] <= '{size_m1: reg_wdata[31:16], attr: reg_wdata[15:8],
                                   target: reg_wdata[7:4], en: reg_wdata[0]};
                if (widx == 32'(win_offset(w, NR, HOLE) / 4 + 1))
                    base_q[w] <= '{hi: reg_wdata[3:0], lo: reg_wdata[31:16]};
            end
            for (int w = 0; w < NR; w++) begin
                if (widx == 32'(win_offset(w, NR, HOLE) / 4 + 2))
                    remap_q[w].lo <= reg_wdata[31:16];
                if (widx == 32'(win_offset(w, NR, HOLE) / 4 + 3))
                    remap_q[w].hi <= reg_wdata[3:0];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int w = 0; w < NW; w++) begin
            if (widx == 32'(win_offset(w, NR, HOLE) / 4))
                reg_rdata = {ctrl_q[w].size_m1, ctrl_q[w].attr, ctrl_q[w].target, 3'b000, ctrl_q[w].en};
            if (widx == 32'(win_offset(w, NR, HOLE) / 4 + 1))
                reg_rdata = {base_q[w].lo, 12'h000, base_q[w].hi};
        end
        for (int w = 0; w < NR; w++) begin
            if (widx == 32'(win_offset(w, NR, HOLE) / 4 + 2))
                reg_rdata = {remap_q[w].lo, 16'h0000};
            if (widx == 32'(win_offset(w, NR, HOLE) / 4 + 3))
                reg_rdata = {28'h0000000, remap_q[w].hi};
        end
        if (widx == 32'(STATUS_WORD))
            reg_rdata = 32'(inval_vec);
    end

endmodule

// File: rtl/cwd_match.sv
module cwd_match
    import cwd_pkg::*;
(
    input  win_ctrl_t        ctrl,
    input  win_addr_t        base,
    input  logic [PA_W-1:0]  addr,
    output logic             hit,
    output logic             invalid
);
    logic [16:0] size_p1;
    logic        not_pow2;
    logic        misaligned;

    assign size_p1    = {1'b0, ctrl.size_m1} + 17'd1;
    assign not_pow2   = (size_p1 & {1'b0, ctrl.size_m1}) != 17'd0;
    assign misaligned = (base.lo & ctrl.size_m1) != 16'h0000;

    assign hit     = ctrl.en && (addr[35:32] == base.hi)
                     && (((addr[31:16] ^ base.lo) & ~ctrl.size_m1) == 16'h0000);
    assign invalid = ctrl.en && (not_pow2 || misaligned);

endmodule

// File: rtl/cwd_select.sv
module cwd_select
    import cwd_pkg::*;
#(
    parameter int NW = DEF_NUM_WIN,
    parameter int NR = DEF_NUM_REMAP,
    parameter int WW = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [PA_W-1:0]  lk_addr,
    input  logic [NW-1:0]    hit_vec,
    input  win_ctrl_t        ctrl_q  [NW],
    input  win_addr_t        remap_q [NR],
    output logic             lk_rsp_valid,
    output logic             lk_hit,
    output logic [3:0]       lk_target,
    output logic [7:0]       lk_attr,
    output logic [WW-1:0]    lk_win,
    output logic             lk_overlap,
    output logic [PA_W-1:0]  lk_addr_out
);
    typedef struct packed {
        logic            hit;
        logic [3:0]      target;
        logic [7:0]      attr;
        logic [WW-1:0]   win;
        logic            overlap;
        logic [PA_W-1:0] addr;
    } result_t;

    logic [PA_W-1:0] xl_addr [NW];
    result_t nx_res;
    result_t res_q;

    for (genvar w = 0; w < NW; w++) begin : g_xl
        if (w < NR) begin : g_remap
            assign xl_addr[w] = {remap_q[w].hi,
                                 (remap_q[w].lo & ~ctrl_q[w].size_m1) | (lk_addr[31:16] & ctrl_q[w].size_m1),
                                 lk_addr[15:0]};
        end else begin : g_pass
            assign xl_addr[w] = lk_addr;
        end
    end

    always_comb begin
        nx_res         = '0;
        nx_res.addr    = lk_addr;
        nx_res.overlap = $countones(hit_vec) > 1;
        for (int w = NW - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                nx_res.hit    = 1'b1;
                nx_res.win    = w[WW-1:0];
                nx_res.target = ctrl_q[w].target;
                nx_res.attr   = ctrl_q[w].attr;
                nx_res.addr   = xl_addr[w];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_rsp_valid <= 1'b0;
            res_q        <= '0;
        end else begin
            lk_rsp_valid <= lk_req;
            if (lk_req) res_q <= nx_res;
        end
    end

    assign lk_hit      = res_q.hit;
    assign lk_target   = res_q.target;
    assign lk_attr     = res_q.attr;
    assign lk_win      = res_q.win;
    assign lk_overlap  = res_q.overlap;
    assign lk_addr_out = res_q.addr;

endmodule

// File: rtl/cpu_win_decoder.sv
module cpu_win_decoder
    import cwd_pkg::*;
#(
    parameter int NUM_WIN   = DEF_NUM_WIN,
    parameter int NUM_REMAP = DEF_NUM_REMAP,
    parameter int HOLE      = DEF_HOLE,
    parameter int REG_AW    = $clog2(win_offset(NUM_WIN, NUM_REMAP, HOLE) + 4),
    parameter int WIN_W     = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              lk_req,
    input  logic [PA_W-1:0]   lk_addr,
    output logic              lk_rsp_valid,
    output logic              lk_hit,
    output logic [3:0]        lk_target,
    output logic [7:0]        lk_attr,
    output logic [WIN_W-1:0]  lk_win,
    output logic              lk_overlap,
    output logic [PA_W-1:0]   lk_addr_out
);
    win_ctrl_t          ctrl_q  [NUM_WIN];
    win_addr_t          base_q  [NUM_WIN];
    win_addr_t          remap_q [NUM_REMAP];
    logic [NUM_WIN-1:0] hit_vec;
    logic [NUM_WIN-1:0] inval_vec;
    logic [NUM_WIN-1:0] en_vec;

    cwd_regfile #(.NW(NUM_WIN), .NR(NUM_REMAP), .HOLE(HOLE), .AW(REG_AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .inval_vec (inval_vec),
        .reg_rdata (reg_rdata),
        .ctrl_q    (ctrl_q),
        .base_q    (base_q),
        .remap_q   (remap_q)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        cwd_match u_match (
            .ctrl    (ctrl_q[w]),
            .base    (base_q[w]),
            .addr    (lk_addr),
            .hit     (hit_vec[w]),
            .invalid (inval_vec[w])
        );
        assign en_vec[w] = ctrl_q[w].en;
    end

    cwd_select #(.NW(NUM_WIN), .NR(NUM_REMAP), .WW(WIN_W)) u_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_req       (lk_req),
        .lk_addr      (lk_addr),
        .hit_vec      (hit_vec),
        .ctrl_q       (ctrl_q),
        .remap_q      (remap_q),
        .lk_rsp_valid (lk_rsp_valid),
        .lk_hit       (lk_hit),
        .lk_target    (lk_target),
        .lk_attr      (lk_attr),
        .lk_win       (lk_win),
        .lk_overlap   (lk_overlap),
        .lk_addr_out  (lk_addr_out)
    );

endmodule

// File: rtl/cwd_checker.sv
module cwd_checker
    import cwd_pkg::*;
#(
    parameter int NW = DEF_NUM_WIN,
    parameter int NR = DEF_NUM_REMAP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_req,
    input  logic [PA_W-1:0] lk_addr,
    input  logic            lk_rsp_valid,
    input  logic            lk_hit,
    input  logic [4:0]      lk_win,
    input  logic            lk_overlap,
    input  logic [PA_W-1:0] lk_addr_out,
    input  logic [NW-1:0]   hit_vec,
    input  logic [NW-1:0]   en_vec
);
    logic [NW-1:0]   hit_d;
    logic [NW-1:0]   en_d;
    logic [PA_W-1:0] addr_d;
    logic [NW-1:0]   low_mask;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_d  <= '0;
            en_d   <= '0;
            addr_d <= '0;
        end else if (lk_req) begin
            hit_d  <= hit_vec;
            en_d   <= en_vec;
            addr_d <= lk_addr;
        end
    end

    assign low_mask = (NW'(1) << lk_win) - NW'(1);

    a_r12_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_rsp_valid);
    a_r12_no_rsp_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_rsp_valid);
    a_r4_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        lk_rsp_valid && lk_hit |-> en_d[lk_win]);
    a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        lk_rsp_valid && lk_hit |-> hit_d[lk_win] && ((hit_d & low_mask) == '0));
    a_r6_overlap_has_hit: assert property (@(posedge clk) disable iff (!rst_n)
        lk_overlap |-> lk_hit);
    a_r6_multi_flags_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        lk_rsp_valid && ($countones(hit_d) >= 2) |-> lk_overlap);
    a_r8_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        lk_rsp_valid && (!lk_hit || 32'(lk_win) >= NR) |-> lk_addr_out == addr_d);
    a_r7_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_rsp_valid |-> lk_addr_out[15:0] == addr_d[15:0]);

endmodule

bind cpu_win_decoder cwd_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_req       (lk_req),
    .lk_addr      (lk_addr),
    .lk_rsp_valid (lk_rsp_valid),
    .lk_hit       (lk_hit),
    .lk_win       (lk_win),
    .lk_overlap   (lk_overlap),
    .lk_addr_out  (lk_addr_out),
    .hit_vec      (hit_vec),
    .en_vec       (en_vec)
);

// File: tb/cpu_win_decoder_tb_top.sv
module cpu_win_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_req = 1'b0;
    logic [35:0] lk_addr = '0;
    logic        lk_rsp_valid, lk_hit, lk_overlap;
    logic [3:0]  lk_target;
    logic [7:0]  lk_attr;
    logic [4:0]  lk_win;
    logic [35:0] lk_addr_out;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    cpu_win_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_req(lk_req), .lk_addr(lk_addr),
        .lk_rsp_valid(lk_rsp_valid), .lk_hit(lk_hit), .lk_target(lk_target), .lk_attr(lk_attr),
        .lk_win(lk_win), .lk_overlap(lk_overlap), .lk_addr_out(lk_addr_out)
    );

    // valid, hit, win, target, attr, overlap, translated address
    typedef struct packed {
        logic [35:0] addr;
        logic        hit;
        logic [4:0]  win;
        logic [3:0]  tgt;
        logic [7:0]  attr;
        logic        ovl;
        logic [35:0] out;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{36'h0_1005_1234, 1'b1, 5'd0,  4'h1, 8'h2A, 1'b1, 36'h3_2235_1234},
        '{36'h0_1080_0010, 1'b1, 5'd10, 4'h6, 8'h11, 1'b0, 36'h0_1080_0010},
        '{36'h4_8000_FFFF, 1'b1, 5'd9,  4'h5, 8'h07, 1'b0, 36'h4_8000_FFFF},
        '{36'h4_8001_0000, 1'b0, 5'd0,  4'h0, 8'h00, 1'b0, 36'h4_8001_0000},
        '{36'h0_8000_0000, 1'b0, 5'd0,  4'h0, 8'h00, 1'b0, 36'h0_8000_0000},
        '{36'h0_2000_0000, 1'b0, 5'd0,  4'h0, 8'h00, 1'b0, 36'h0_2000_0000},
        '{36'h0_0003_0004, 1'b1, 5'd3,  4'h2, 8'h33, 1'b0, 36'h0_5553_0004},
        '{36'h0_0601_0000, 1'b1, 5'd4,  4'h3, 8'h44, 1'b0, 36'h0_0001_0000}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic look(input string req, input logic [35:0] a, input logic hit, input logic [4:0] win,
                        input logic [3:0] tgt, input logic [7:0] attr, input logic ovl, input logic [35:0] out);
        @(negedge clk);
        lk_req = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_req = 1'b0;
        #1;
        check(req, {8'h0, lk_rsp_valid, lk_hit, lk_win, lk_target, lk_attr, lk_overlap, lk_addr_out},
                   {8'h0, 1'b1, hit, win, tgt, attr, ovl, out});
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_chk("R1 ctrl w0", 8'h00, 32'h0);
        rd_chk("R1 ctrl w9", 8'h98, 32'h0);
        rd_chk("R1 status", 8'hF0, 32'h0);
        look("R1 no hit after reset", 36'h0_0000_0000, 1'b0, 5'd0, 4'h0, 8'h00, 1'b0, 36'h0);

        // Programming, R9 offset map used throughout
        wr(8'h00, 32'h000F2A11); wr(8'h04, 32'h1000_0000); wr(8'h08, 32'h2230_0000); wr(8'h0C, 32'h0000_0003);
        wr(8'h30, 32'h00033321); wr(8'h34, 32'h0001_0000); wr(8'h38, 32'h5550_0000);
        wr(8'h40, 32'h00054431); wr(8'h44, 32'h0600_0000);
        wr(8'h98, 32'h00000751); wr(8'h9C, 32'h8000_0004);
        wr(8'hA0, 32'h00FF1161); wr(8'hA4, 32'h1000_0000);
        wr(8'hE8, 32'h00000070); wr(8'hEC, 32'h2000_0000);

        // R5 R6 R7 R8 table walk; row 5 covers the disabled window (R4)
        for (int i = 0; i < 8; i++)
            look($sformatf("R5 R6 R7 R8 R4 table row %0d", i), VEC[i].addr, VEC[i].hit, VEC[i].win,
                 VEC[i].tgt, VEC[i].attr, VEC[i].ovl, VEC[i].out);

        // R12: valid lasts one cycle only
        @(negedge clk); #1;
        check("R12 valid drops", 64'(lk_rsp_valid), 64'(0));
        check("R12 result held", 64'(lk_addr_out), 64'(36'h0_0001_0000));

        // R2: control layout and read-back
        rd_chk("R2 ctrl readback", 8'h00, 32'h000F2A11);
        wr(8'h10, 32'h0000000E);
        rd_chk("R2 bits 3:1 read zero", 8'h10, 32'h0);

        // R9: high-window offsets
        rd_chk("R9 w9 ctrl", 8'h98, 32'h00000751);
        rd_chk("R9 w9 base", 8'h9C, 32'h8000_0004);
        rd_chk("R9 w19 ctrl", 8'hE8, 32'h00000070);
        rd_chk("R9 w19 base", 8'hEC, 32'h2000_0000);
        rd_chk("R9 w3 remap lo", 8'h38, 32'h5550_0000);

        // R3: field masks
        wr(8'h24, 32'hFFFF_FFFF);
        rd_chk("R3 base mask", 8'h24, 32'hFFFF_000F);
        wr(8'h2C, 32'hFFFF_FFFF);
        rd_chk("R3 remap hi mask", 8'h2C, 32'h0000_000F);
        wr(8'h28, 32'hFFFF_FFFF);
        rd_chk("R3 remap lo mask", 8'h28, 32'hFFFF_0000);

        // R11: invalid status (w3 misaligned, w4 non power of two)
        rd_chk("R11 status", 8'hF0, 32'h0000_0018);

        // R10: hole and beyond-status offsets
        wr(8'h84, 32'hDEAD_BEEF);
        rd_chk("R10 hole reads zero", 8'h84, 32'h0);
        wr(8'hF4, 32'hDEAD_BEEF);
        rd_chk("R10 above status", 8'hF4, 32'h0);
        wr(8'hF0, 32'hFFFF_FFFF);
        rd_chk("R10 status write ignored", 8'hF0, 32'h0000_0018);
        rd_chk("R10 w0 ctrl untouched", 8'h00, 32'h000F2A11);

        // R4: clearing window 0 leaves window 10 alone
        wr(8'h00, 32'h0); wr(8'h04, 32'h0);
        rd_chk("R4 cleared ctrl", 8'h00, 32'h0);
        look("R4 cleared window no longer wins", 36'h0_1005_1234, 1'b1, 5'd10, 4'h6, 8'h11, 1'b0, 36'h0_1005_1234);

        summary();
        $finish;
    end

endmodule